// File: doc/BRIEF.md
# Regulator Output Power-Good and Fault Supervisor

This block watches a single regulator channel through a set of digital comparator flags: two bounds of the power-good window, the over-voltage and under-voltage trip points, soft-start completion, and two temperature flags that form a hysteresis band. Each flag passes through its own deglitch counter before anything else looks at it. The filtered flags then drive four outputs. The first is a power-good output. The second is a crowbar request that turns the low-side switch on while the output is too high. The third is a shutdown output. The fourth is a one-cycle request to restart the soft-start ramp after a thermal trip.

The fault responses differ on purpose. An over-voltage crowbar releases by itself once the filtered flag drops. An under-voltage trip only counts once soft start has finished, and it then holds the channel off until the enable input or the supply-good flag goes low. An over-temperature trip holds the channel off until the die has cooled below a lower threshold, and then asks for a fresh soft start.

Top module: `pwr_fault_supervisor`

## Requirements
- R1: A raw flag change reaches the filtered logic only after the flag has held its new level for FILT_CYCLES consecutive clock edges. A pulse shorter than that has no effect on any output.
- R2: `pgood` is high only when the filtered soft-start flag is high, both filtered window flags (`flag_below_win`, `flag_above_win`) are low, and `shutdown` is low.
- R3: `crowbar_req` follows the filtered `flag_over` with no latching. It drops within FILT_CYCLES edges of the raw flag falling.
- R4: A filtered under-voltage flag has no effect while the filtered soft-start flag is low.
- R5: A filtered under-voltage flag seen together with a filtered soft-start flag latches `shutdown` high on the next edge. The latch stays set after the under-voltage flag clears.
- R6: The under-voltage latch clears on a clock edge at which `en` or `uvlo_ok` is low.
- R7: A filtered `flag_temp_hot` sets `shutdown`. The trip holds until the filtered `flag_temp_hot` is low and the filtered `flag_temp_cool` is high. On the edge that releases it, `restart_ss` pulses high for exactly one cycle.
- R8: While `shutdown` is high, `pgood` and `crowbar_req` are both low.
- R9: In reset with `en` and `uvlo_ok` high, all of `pgood`, `crowbar_req`, `shutdown` and `restart_ss` are low.
- R10: `shutdown` is high whenever `en` or `uvlo_ok` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Channel enable, high to run |
| uvlo_ok | input | 1 | Supply above lockout threshold |
| flag_below_win | input | 1 | Output below lower power-good bound |
| flag_above_win | input | 1 | Output above upper power-good bound |
| flag_over | input | 1 | Output above over-voltage trip point |
| flag_under | input | 1 | Output below under-voltage trip point |
| flag_ss_done | input | 1 | Soft-start ramp complete |
| flag_temp_hot | input | 1 | Die above shutdown temperature |
| flag_temp_cool | input | 1 | Die below resume temperature |
| pgood | output | 1 | Power-good, high when output is good |
| crowbar_req | output | 1 | Force low-side switch on |
| shutdown | output | 1 | Channel held off |
| restart_ss | output | 1 | One-cycle request for a new soft start |

## Verification
The hardest state to reach is the thermal release. The bench has to hold the die in the band between the two thresholds, with the hot flag already cleared and the cool flag not yet set, and show that `shutdown` stays high there. It then raises the cool flag and samples the edge at which the trip releases, where the single `restart_ss` pulse appears, along with the edges just before and after it. The under-voltage path is similar. The bench first shows that a dip below the trip point is ignored while soft start is incomplete. It then latches the fault after soft start, removes the dip, and clears the latch separately through `en` and through `uvlo_ok`.

// File: rtl/pfs_pkg.sv
// Shared constants for the power-good and fault supervisor.
// Assumes all comparator flags are active high.
package pfs_pkg;
    localparam int FLG_BELOW  = 0;
    localparam int FLG_ABOVE  = 1;
    localparam int FLG_OVER   = 2;
    localparam int FLG_UNDER  = 3;
    localparam int FLG_SS     = 4;
    localparam int FLG_HOT    = 5;
    localparam int FLG_COOL   = 6;
    localparam int NUM_FLAGS  = 7;
endpackage

// File: rtl/pfs_deglitch.sv
// Deglitch filter for one flag. The output takes the raw level once the raw
// level has differed from the output for CYCLES consecutive edges.
// Assumes CYCLES >= 1 and that the raw input is already synchronous.
module pfs_deglitch #(
    parameter int CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Count edges of disagreement and adopt the raw level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            filt <= 1'b0;
        end else if (raw == filt) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            filt <= raw;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pfs_fault_state.sv
// Fault state for the supervisor: the under-voltage latch, armed only after
// soft start, and the thermal trip with its hysteresis band and restart pulse.
// Assumes filtered flags as inputs; active means enabled and supply good.
module pfs_fault_state (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic ss_f,
    input  logic uv_f,
    input  logic hot_f,
    input  logic cool_f,
    output logic uv_lat,
    output logic ot_trip,
    output logic restart_ss
);
    logic ot_release;

    // Release condition for the thermal trip.
    always_comb ot_release = ot_trip && !hot_f && cool_f;

    // Under-voltage latch: set after soft start, cleared when inactive.
    always_ff @(posedge clk) begin
        if (!rst_n)             uv_lat <= 1'b0;
        else if (!active)       uv_lat <= 1'b0;
        else if (ss_f && uv_f)  uv_lat <= 1'b1;
    end

    // Thermal trip with hysteresis between hot and cool thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n)          ot_trip <= 1'b0;
        else if (hot_f)      ot_trip <= 1'b1;
        else if (ot_release) ot_trip <= 1'b0;
    end

    // One-cycle soft-start restart request on thermal release.
    always_ff @(posedge clk) begin
        if (!rst_n) restart_ss <= 1'b0;
        else        restart_ss <= ot_release;
    end
endmodule

// File: rtl/pwr_fault_supervisor.sv
// Power-good and output fault supervisor for one regulator channel.
// Filters each comparator flag, then derives power-good, a self-releasing
// over-voltage crowbar request, a shutdown and a soft-start restart request.
// Assumes flags are synchronous to clk; FILT_CYCLES sets the filter length.
module pwr_fault_supervisor #(
    parameter int FILT_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic uvlo_ok,
    input  logic flag_below_win,
    input  logic flag_above_win,
    input  logic flag_over,
    input  logic flag_under,
    input  logic flag_ss_done,
    input  logic flag_temp_hot,
    input  logic flag_temp_cool,
    output logic pgood,
    output logic crowbar_req,
    output logic shutdown,
    output logic restart_ss
);
    import pfs_pkg::*;

    logic [NUM_FLAGS-1:0] raw_vec;
    logic [NUM_FLAGS-1:0] flt_vec;
    logic active, ss_f, ov_f, uv_lat, ot_trip, in_window;

    // Gather raw flags in package index order.
    always_comb begin
        raw_vec            = '0;
        raw_vec[FLG_BELOW] = flag_below_win;
        raw_vec[FLG_ABOVE] = flag_above_win;
        raw_vec[FLG_OVER]  = flag_over;
        raw_vec[FLG_UNDER] = flag_under;
        raw_vec[FLG_SS]    = flag_ss_done;
        raw_vec[FLG_HOT]   = flag_temp_hot;
        raw_vec[FLG_COOL]  = flag_temp_cool;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_filt
        pfs_deglitch #(.CYCLES(FILT_CYCLES)) i_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_vec[g]),
            .filt (flt_vec[g])
        );
    end

    // Named views of filtered flags and the run condition.
    always_comb begin
        active    = en && uvlo_ok;
        ss_f      = flt_vec[FLG_SS];
        ov_f      = flt_vec[FLG_OVER];
        in_window = !flt_vec[FLG_BELOW] && !flt_vec[FLG_ABOVE];
    end

    pfs_fault_state i_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .ss_f      (ss_f),
        .uv_f      (flt_vec[FLG_UNDER]),
        .hot_f     (flt_vec[FLG_HOT]),
        .cool_f    (flt_vec[FLG_COOL]),
        .uv_lat    (uv_lat),
        .ot_trip   (ot_trip),
        .restart_ss(restart_ss)
    );

    // Output decode: shutdown gates both power-good and the crowbar.
    always_comb begin
        shutdown    = !active || uv_lat || ot_trip;
        crowbar_req = ov_f && !shutdown;
        pgood       = ss_f && in_window && !shutdown;
    end
endmodule

// File: rtl/pfs_checker.sv
// Property checker for the supervisor, attached by bind below.
// Assumes the filtered soft-start and over-voltage flags and the UV latch.
module pfs_checker (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic uvlo_ok,
    input logic pgood,
    input logic crowbar_req,
    input logic shutdown,
    input logic restart_ss,
    input logic ss_f,
    input logic ov_f,
    input logic uv_lat
);
    AST_PG_NEEDS_SS: assert property (@(posedge clk) disable iff (!rst_n)
        pgood |-> ss_f && !shutdown); // R2
    AST_CROWBAR_FROM_OV: assert property (@(posedge clk) disable iff (!rst_n)
        crowbar_req |-> ov_f); // R3
    AST_UV_ARMED_BY_SS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uv_lat) |-> $past(ss_f)); // R4
    AST_UV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_lat && en && uvlo_ok) |=> uv_lat); // R5
    AST_UV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && uvlo_ok) |=> !uv_lat); // R6
    AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_ss |=> !restart_ss); // R7
    AST_SD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> !pgood && !crowbar_req); // R8
    AST_INACTIVE_SD: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && uvlo_ok) |-> shutdown); // R10
endmodule

bind pwr_fault_supervisor pfs_checker i_pfs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .uvlo_ok    (uvlo_ok),
    .pgood      (pgood),
    .crowbar_req(crowbar_req),
    .shutdown   (shutdown),
    .restart_ss (restart_ss),
    .ss_f       (ss_f),
    .ov_f       (ov_f),
    .uv_lat     (uv_lat)
);

// File: tb/test_pwr_fault_supervisor.sv
module test_pwr_fault_supervisor;
    localparam int N    = 4;
    localparam int HOLD = N + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1, uvlo_ok = 1'b1;
    logic f_below = 1'b0, f_above = 1'b0, f_over = 1'b0, f_under = 1'b0;
    logic f_ss = 1'b0, f_hot = 1'b0, f_cool = 1'b1;
    logic pgood, crowbar_req, shutdown, restart_ss;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwr_fault_supervisor #(.FILT_CYCLES(N)) i_pwr_fault_supervisor (
        .clk(clk), .rst_n(rst_n), .en(en), .uvlo_ok(uvlo_ok),
        .flag_below_win(f_below), .flag_above_win(f_above),
        .flag_over(f_over), .flag_under(f_under), .flag_ss_done(f_ss),
        .flag_temp_hot(f_hot), .flag_temp_cool(f_cool),
        .pgood(pgood), .crowbar_req(crowbar_req), .shutdown(shutdown),
        .restart_ss(restart_ss)
    );

    // Vector: {en,uvlo_ok,ss,below,above,over,under,hot,cool, pg,cb,sd}
    localparam logic [11:0] VEC [11] = '{
        12'b110_0000_01_000,
        12'b111_0000_01_100,
        12'b111_1000_01_000,
        12'b111_0100_01_000,
        12'b111_0110_01_010,
        12'b111_0000_01_100,
        12'b110_0001_01_000,
        12'b010_0000_01_001,
        12'b111_0000_01_100,
        12'b011_0010_01_001,
        12'b111_0000_01_100
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b {pg,cb,sd,rs}", req, act, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {pgood, crowbar_req, shutdown, restart_ss};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset state with enable and supply good
        step(3);
        chk("R9 reset", outs(), 4'b0000);
        rst_n = 1'b1;

        // Table walk: steady-state responses (R2 R3 R4 R8 R10)
        for (int i = 0; i < 11; i++) begin
            {en, uvlo_ok, f_ss, f_below, f_above, f_over, f_under, f_hot, f_cool} = VEC[i][11:3];
            step(HOLD);
            chk($sformatf("R2/R3/R4/R8/R10 vector %0d", i), outs(), {VEC[i][2:0], 1'b0});
        end

        // R1: pulse one edge short of the filter length is ignored
        f_over = 1'b1;
        for (int k = 0; k < N - 1; k++) begin
            step(1);
            chk("R1 short pulse", {1'b0, crowbar_req, 2'b00}, 4'b0000);
        end
        f_over = 1'b0;
        step(HOLD);
        chk("R1 after short pulse", outs(), 4'b1000);

        // R1 R3: exact latency of assert and release of the crowbar
        f_over = 1'b1;
        step(N - 1);
        chk("R1 crowbar before limit", outs(), 4'b1000);
        step(1);
        chk("R3 crowbar at limit", outs(), 4'b1100);
        f_over = 1'b0;
        step(N - 1);
        chk("R3 crowbar held by filter", outs(), 4'b1100);
        step(1);
        chk("R3 crowbar released", outs(), 4'b1000);

        // R5: under-voltage after soft start latches
        f_under = 1'b1;
        step(N);
        chk("R5 uv filtered, latch next", outs(), 4'b1000);
        step(1);
        chk("R5 uv latched", outs(), 4'b0010);
        f_under = 1'b0;
        step(HOLD);
        chk("R5 latch holds after uv clears", outs(), 4'b0010);
        // R6: enable toggle clears
        en = 1'b0;
        step(2);
        chk("R6 en low", outs(), 4'b0010);
        en = 1'b1;
        step(1);
        chk("R6 cleared by en toggle", outs(), 4'b1000);
        // R6: supply-good drop clears
        f_under = 1'b1;
        step(HOLD);
        f_under = 1'b0;
        step(HOLD);
        chk("R6 relatched", outs(), 4'b0010);
        uvlo_ok = 1'b0;
        step(2);
        uvlo_ok = 1'b1;
        step(1);
        chk("R6 cleared by uvlo drop", outs(), 4'b1000);

        // R7: thermal trip, hysteresis band, restart pulse
        f_hot = 1'b1;
        f_cool = 1'b0;
        step(HOLD);
        chk("R7 hot trip", outs(), 4'b0010);
        f_hot = 1'b0;
        step(HOLD);
        chk("R7 held in band", outs(), 4'b0010);
        f_cool = 1'b1;
        step(N);
        chk("R7 cool filtered, not yet released", outs(), 4'b0010);
        step(1);
        chk("R7 release with restart pulse", outs(), 4'b1001);
        step(1);
        chk("R7 restart pulse one cycle", outs(), 4'b1000);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule